// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block sits between a UART serializer and the system bus. It buffers bytes in two 16-entry FIFOs. The transmit FIFO is filled from the bus and emptied by the serializer. The receive FIFO is filled by the serializer and emptied by the bus. From the fill levels it raises one DMA request line per direction, so that a DMA controller can move data in bursts instead of byte by byte under interrupt control.

A single control register holds three things: a DMA-mode enable, a 4-bit trigger level and a line-status interrupt enable. The two request lines use opposite senses of the trigger.
- The transmit request asks for more data while the transmit FIFO is at or below the trigger.
- The receive request asks for draining while the receive FIFO is at or above the trigger.

A receive error, or a byte lost to a full receive FIFO, sets a line-status pending flag. Software can turn that flag into an interrupt, so that a DMA transfer stalled by bad data is noticed.

Serial framing, the bus protocol and the DMA controller itself lie outside this block.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset, both fill levels are 0, all request, overrun and interrupt outputs are low, and the control register reads 0x00.
- R2: Each FIFO holds up to 16 bytes in first-in first-out order. The data output always shows the oldest stored byte, and a pop removes it.
- R3: A push to a full FIFO without a pop in the same cycle drops the byte and sets that FIFO's sticky overrun output (`tx_ovr_o` or `rx_ovr_o`). A pop on an empty FIFO is ignored. A pulse on `ls_clr_i` clears both overrun outputs; a new overrun in the same cycle takes priority over the clear.
- R4: A push and a pop in the same cycle on a non-empty FIFO leave its level unchanged.
- R5: A control write places DMA enable in bit 0, line-status interrupt enable in bit 1 and the trigger level in bits 7:4. Bits 3:2 are not stored and read back as 0.
- R6: `tx_req_o` is high in the cycle after a clock edge at which DMA enable was 1 and the transmit level was less than or equal to the trigger. Otherwise it is low.
- R7: `rx_req_o` is high in the cycle after a clock edge at which DMA enable was 1 and the receive level was greater than or equal to the trigger. Otherwise it is low.
- R8: While DMA enable is 0, both request outputs are low one cycle later, whatever the fill levels.
- R9: A receive push with `rx_err_i` high, or a receive overrun, sets a line-status pending flag. `line_irq_o` is that flag ANDed with the interrupt enable. `ls_clr_i` clears the flag, and a new event in the same cycle takes priority over the clear.
- R10: A transmit burst of 16 minus trigger bytes, started on a transmit request, fills the FIFO without overrun. A receive burst of trigger bytes, started on a receive request, never pops an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control write data |
| cfg_rdata_o | output | 8 | Control register readback |
| ls_clr_i | input | 1 | Clears the overrun flags and the line-status pending flag |
| tx_push_i | input | 1 | Bus writes a transmit byte |
| tx_data_i | input | DATA_W | Transmit byte in |
| tx_pop_i | input | 1 | Serializer takes a transmit byte |
| tx_data_o | output | DATA_W | Oldest transmit byte |
| tx_level_o | output | 5 | Transmit fill level |
| tx_ovr_o | output | 1 | Transmit overrun, sticky |
| tx_req_o | output | 1 | Transmit DMA request |
| rx_push_i | input | 1 | Serializer delivers a receive byte |
| rx_data_i | input | DATA_W | Receive byte in |
| rx_err_i | input | 1 | Delivered byte carries a receive error |
| rx_pop_i | input | 1 | Bus takes a receive byte |
| rx_data_o | output | DATA_W | Oldest receive byte |
| rx_level_o | output | 5 | Receive fill level |
| rx_ovr_o | output | 1 | Receive overrun, sticky |
| rx_req_o | output | 1 | Receive DMA request |
| line_irq_o | output | 1 | Line-status interrupt |

## Verification
The hardest situation to reach is a request output that must stay low while the fill level would assert it. This happens when DMA enable drops with both FIFOs sitting past their thresholds. The stimulus first fills the receive FIFO to 8 bytes and leaves one byte in the transmit FIFO. It then programs trigger 8 with DMA on, which raises both requests, and only then rewrites the register with DMA off. The trigger extremes 0 and 15 follow, along with a full-depth overrun on each FIFO and the exact burst of 16 minus trigger bytes. A scoreboard queue checks that no dropped byte ever appears at the data outputs.

// File: rtl/ufd_pkg.sv
package ufd_pkg;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned TRIG_W     = $clog2(FIFO_DEPTH);
  localparam int unsigned CFG_W      = 8;
  // control register bit positions
  localparam int unsigned BIT_DMA    = 0;
  localparam int unsigned BIT_LSIE   = 1;
  localparam int unsigned TRIG_LSB   = 4;

  typedef struct packed {
    logic [TRIG_W-1:0] trig;
    logic              lsie;
    logic              dma_en;
  } cfg_t;
endpackage

// File: rtl/ufd_fifo.sv
module ufd_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] level_o,
  output logic          drop_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop_i && (cnt_q != '0);
  // full FIFO still accepts a byte when a pop frees a slot in the same cycle
  assign do_push = push_i && ((cnt_q != CW'(DEPTH)) || do_pop);
  assign drop_o  = push_i && !do_push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign level_o = cnt_q;
endmodule

// File: rtl/ufd_dreq.sv
module ufd_dreq #(
  parameter int unsigned LVL_W       = 5,
  parameter int unsigned TRIG_W      = 4,
  parameter bit          AT_OR_ABOVE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  output logic              req_o
);
  logic [LVL_W-1:0] thr;
  logic             hit;

  assign thr = LVL_W'(trig_i);

  generate
    if (AT_OR_ABOVE) begin : g_drain
      assign hit = (level_i >= thr);
    end else begin : g_fill
      assign hit = (level_i <= thr);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= en_i && hit;
  end
endmodule

// File: rtl/ufd_regs.sv
module ufd_regs
  import ufd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output cfg_t             cfg_o,
  input  logic             tx_drop_i,
  input  logic             rx_drop_i,
  input  logic             rx_err_i,
  input  logic             clr_i,
  output logic             tx_ovr_o,
  output logic             rx_ovr_o,
  output logic             ls_pend_o,
  output logic             irq_o
);
  cfg_t cfg_q;
  logic tx_ovr_q, rx_ovr_q, pend_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i[TRIG_LSB-1:BIT_LSIE+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.dma_en <= wdata_i[BIT_DMA];
      cfg_q.lsie   <= wdata_i[BIT_LSIE];
      cfg_q.trig   <= wdata_i[TRIG_LSB +: TRIG_W];
    end
  end

  // set beats clear on all sticky flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ovr_q <= 1'b0;
      rx_ovr_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (tx_drop_i)   tx_ovr_q <= 1'b1;
      else if (clr_i)  tx_ovr_q <= 1'b0;
      if (rx_drop_i)   rx_ovr_q <= 1'b1;
      else if (clr_i)  rx_ovr_q <= 1'b0;
      if (rx_err_i || rx_drop_i) pend_q <= 1'b1;
      else if (clr_i)            pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[BIT_DMA]             = cfg_q.dma_en;
    rdata_o[BIT_LSIE]            = cfg_q.lsie;
    rdata_o[TRIG_LSB +: TRIG_W]  = cfg_q.trig;
  end

  assign cfg_o     = cfg_q;
  assign tx_ovr_o  = tx_ovr_q;
  assign rx_ovr_o  = rx_ovr_q;
  assign ls_pend_o = pend_q;
  assign irq_o     = pend_q && cfg_q.lsie;
endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
  import ufd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              ls_clr_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic              tx_ovr_o,
  output logic              tx_req_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_err_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              rx_ovr_o,
  output logic              rx_req_o,
  output logic              line_irq_o
);
  cfg_t              cfg;
  logic              dma_en, lsie;
  logic [TRIG_W-1:0] trig;
  logic              tx_drop, rx_drop, ls_pend;

  assign dma_en = cfg.dma_en;
  assign lsie   = cfg.lsie;
  assign trig   = cfg.trig;

  ufd_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .cfg_o     (cfg),
    .tx_drop_i (tx_drop),
    .rx_drop_i (rx_drop),
    .rx_err_i  (rx_push_i && rx_err_i),
    .clr_i     (ls_clr_i),
    .tx_ovr_o  (tx_ovr_o),
    .rx_ovr_o  (rx_ovr_o),
    .ls_pend_o (ls_pend),
    .irq_o     (line_irq_o)
  );

  ufd_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .level_o (tx_level_o),
    .drop_o  (tx_drop)
  );

  ufd_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .level_o (rx_level_o),
    .drop_o  (rx_drop)
  );

  // transmit asks for data at or below trigger, receive asks for draining at or above
  ufd_dreq #(.LVL_W(LVL_W), .TRIG_W(TRIG_W), .AT_OR_ABOVE(1'b0)) i_tx_dreq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (dma_en),
    .level_i (tx_level_o),
    .trig_i  (trig),
    .req_o   (tx_req_o)
  );

  ufd_dreq #(.LVL_W(LVL_W), .TRIG_W(TRIG_W), .AT_OR_ABOVE(1'b1)) i_rx_dreq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (dma_en),
    .level_i (rx_level_o),
    .trig_i  (trig),
    .req_o   (rx_req_o)
  );
endmodule

// File: rtl/ufd_checker.sv
module ufd_checker
  import ufd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dma_en,
  input logic              lsie,
  input logic [TRIG_W-1:0] trig,
  input logic              ls_pend,
  input logic              ls_clr_i,
  input logic              tx_push_i,
  input logic              tx_pop_i,
  input logic              rx_push_i,
  input logic              rx_pop_i,
  input logic              rx_err_i,
  input logic [LVL_W-1:0]  tx_level_o,
  input logic [LVL_W-1:0]  rx_level_o,
  input logic              tx_ovr_o,
  input logic              rx_ovr_o,
  input logic              tx_req_o,
  input logic              rx_req_o,
  input logic              line_irq_o
);
  logic [LVL_W-1:0] thr;
  assign thr = LVL_W'(trig);

  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level_o <= LVL_W'(FIFO_DEPTH) && rx_level_o <= LVL_W'(FIFO_DEPTH));

  assert_tx_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && !tx_pop_i && tx_level_o == LVL_W'(FIFO_DEPTH))
      |=> (tx_ovr_o && tx_level_o == LVL_W'(FIFO_DEPTH)));

  assert_rx_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && rx_level_o == LVL_W'(FIFO_DEPTH))
      |=> (rx_ovr_o && ls_pend));

  assert_tx_swap_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_pop_i && tx_level_o != '0) |=> $stable(tx_level_o));

  assert_rx_swap_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_pop_i && rx_level_o != '0) |=> $stable(rx_level_o));

  assert_tx_req_on_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en && tx_level_o <= thr) |=> tx_req_o);

  assert_tx_req_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en && tx_level_o > thr) |=> !tx_req_o);

  assert_rx_req_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en && rx_level_o >= thr) |=> rx_req_o);

  assert_rx_req_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_en && rx_level_o < thr) |=> !rx_req_o);

  assert_dma_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en |=> (!tx_req_o && !rx_req_o));

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_irq_o |-> (lsie && ls_pend));

  assert_err_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_err_i) |=> ls_pend);

  assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_clr_i && !rx_push_i && !tx_push_i) |=> (!ls_pend && !tx_ovr_o && !rx_ovr_o));
endmodule

bind uart_fifo_dma ufd_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dma_en     (dma_en),
  .lsie       (lsie),
  .trig       (trig),
  .ls_pend    (ls_pend),
  .ls_clr_i   (ls_clr_i),
  .tx_push_i  (tx_push_i),
  .tx_pop_i   (tx_pop_i),
  .rx_push_i  (rx_push_i),
  .rx_pop_i   (rx_pop_i),
  .rx_err_i   (rx_err_i),
  .tx_level_o (tx_level_o),
  .rx_level_o (rx_level_o),
  .tx_ovr_o   (tx_ovr_o),
  .rx_ovr_o   (rx_ovr_o),
  .tx_req_o   (tx_req_o),
  .rx_req_o   (rx_req_o),
  .line_irq_o (line_irq_o)
);

// File: tb/test_uart_fifo_dma.sv
`timescale 1ns/1ps
module test_uart_fifo_dma;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       ls_clr_i = 1'b0;
  logic       tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] tx_data_i = '0, tx_data_o;
  logic [4:0] tx_level_o, rx_level_o;
  logic       tx_ovr_o, tx_req_o, rx_ovr_o, rx_req_o, line_irq_o;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0, rx_err_i = 1'b0;
  logic [7:0] rx_data_i = '0, rx_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_tx = 0;
  int m_rx = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #10 clk_i = ~clk_i;

  uart_fifo_dma i_uart_fifo_dma (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear_status();
    ls_clr_i = 1'b1;
    @(negedge clk_i);
    ls_clr_i = 1'b0;
  endtask

  // driver: predicts acceptance and queues the expected byte
  task automatic tx_put(input logic [7:0] b);
    tx_push_i = 1'b1; tx_data_i = b;
    if (m_tx < 16) begin txq.push_back(b); m_tx++; end
    @(negedge clk_i);
    tx_push_i = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b, input logic err);
    rx_push_i = 1'b1; rx_data_i = b; rx_err_i = err;
    if (m_rx < 16) begin rxq.push_back(b); m_rx++; end
    @(negedge clk_i);
    rx_push_i = 1'b0; rx_err_i = 1'b0;
  endtask

  // monitor: compares the head against the scoreboard before popping
  task automatic tx_take();
    if (m_tx > 0) begin
      chk("R2 tx order", tx_data_o, txq.pop_front());
      m_tx--;
    end
    tx_pop_i = 1'b1;
    @(negedge clk_i);
    tx_pop_i = 1'b0;
  endtask

  task automatic rx_take();
    if (m_rx > 0) begin
      chk("R2 rx order", rx_data_o, rxq.pop_front());
      m_rx--;
    end
    rx_pop_i = 1'b1;
    @(negedge clk_i);
    rx_pop_i = 1'b0;
  endtask

  task automatic rx_swap(input logic [7:0] b);
    chk("R4 rx swap head", rx_data_o, rxq.pop_front());
    rxq.push_back(b);
    rx_push_i = 1'b1; rx_data_i = b; rx_pop_i = 1'b1;
    @(negedge clk_i);
    rx_push_i = 1'b0; rx_pop_i = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 tx level", tx_level_o, 0);
    chk("R1 rx level", rx_level_o, 0);
    chk("R1 tx req", tx_req_o, 0);
    chk("R1 rx req", rx_req_o, 0);
    chk("R1 irq", line_irq_o, 0);
    chk("R1 ovr", {tx_ovr_o, rx_ovr_o}, 0);
    chk("R1 cfg", cfg_rdata_o, 0);

    // R8 DMA disabled: low requests although levels satisfy trigger 0 on rx
    tx_put(8'h11); tx_put(8'h22); tx_put(8'h33);
    idle(2);
    chk("R8 tx req off", tx_req_o, 0);
    chk("R8 rx req off", rx_req_o, 0);
    chk("R2 tx level", tx_level_o, 3);

    // R5 layout: 0x4D -> dma=1, lsie=0, trig=4, bits 3:2 dropped
    cfg_write(8'h4D);
    chk("R5 readback", cfg_rdata_o, 8'h41);
    idle(1);
    chk("R6 tx req 3<=4", tx_req_o, 1);
    chk("R7 rx req 0<4", rx_req_o, 0);

    tx_put(8'h44); tx_put(8'h55);
    idle(1);
    chk("R6 tx req 5>4", tx_req_o, 0);
    tx_take();
    idle(1);
    chk("R6 tx req at trigger", tx_req_o, 1);

    // R10 burst of 16-4 bytes fills without overrun
    for (int i = 0; i < 12; i++) tx_put(8'h60 + 8'(i));
    chk("R10 tx burst level", tx_level_o, 16);
    chk("R10 tx burst no ovr", tx_ovr_o, 0);
    tx_put(8'hEE);
    chk("R3 tx ovr", tx_ovr_o, 1);
    chk("R3 tx level held", tx_level_o, 16);
    for (int i = 0; i < 16; i++) tx_take();
    chk("R2 tx drained", tx_level_o, 0);
    tx_take();
    chk("R3 pop empty ignored", tx_level_o, 0);
    clear_status();
    chk("R3 ovr cleared", tx_ovr_o, 0);

    // R7 receive threshold at or above
    rx_put(8'hA0, 0); rx_put(8'hA1, 0); rx_put(8'hA2, 0);
    idle(1);
    chk("R7 rx req 3<4", rx_req_o, 0);
    rx_put(8'hA3, 0);
    idle(1);
    chk("R7 rx req at trigger", rx_req_o, 1);
    for (int i = 0; i < 4; i++) rx_take();
    chk("R10 rx burst level", rx_level_o, 0);
    idle(1);
    chk("R7 rx req after drain", rx_req_o, 0);

    // R4 simultaneous push and pop
    rx_put(8'hB0, 0); rx_put(8'hB1, 0);
    rx_swap(8'hB2);
    chk("R4 rx level held", rx_level_o, 2);
    rx_take(); rx_take();

    // R9 error with interrupt disabled, then enabled, then cleared
    rx_put(8'h77, 1);
    idle(1);
    chk("R9 irq masked", line_irq_o, 0);
    cfg_write(8'h43);
    chk("R9 irq on enable", line_irq_o, 1);
    clear_status();
    chk("R9 irq cleared", line_irq_o, 0);
    rx_take();

    // R3/R9 receive overrun
    for (int i = 0; i < 16; i++) rx_put(8'hC0 + 8'(i), 0);
    chk("R9 no irq before ovr", line_irq_o, 0);
    rx_put(8'hFF, 0);
    chk("R3 rx ovr", rx_ovr_o, 1);
    chk("R9 irq on rx ovr", line_irq_o, 1);
    chk("R3 rx level held", rx_level_o, 16);
    for (int i = 0; i < 16; i++) rx_take();
    clear_status();
    chk("R3 rx ovr cleared", rx_ovr_o, 0);

    // trigger 0 extreme
    cfg_write(8'h03);
    idle(1);
    chk("R6 trig0 tx empty", tx_req_o, 1);
    chk("R7 trig0 rx empty", rx_req_o, 1);
    tx_put(8'h99);
    idle(1);
    chk("R6 trig0 tx one", tx_req_o, 0);

    // trigger 15 extreme
    cfg_write(8'hF1);
    idle(1);
    chk("R6 trig15 tx", tx_req_o, 1);
    chk("R7 trig15 rx", rx_req_o, 0);

    // R8 disable while both requests are active
    for (int i = 0; i < 8; i++) rx_put(8'hD0 + 8'(i), 0);
    cfg_write(8'h81);
    idle(1);
    chk("R6 trig8 tx", tx_req_o, 1);
    chk("R7 trig8 rx", rx_req_o, 1);
    cfg_write(8'h80);
    idle(1);
    chk("R8 tx gated", tx_req_o, 0);
    chk("R8 rx gated", rx_req_o, 0);
    for (int i = 0; i < 8; i++) rx_take();
    tx_take();
    chk("R2 final levels", {tx_level_o, rx_level_o}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule